// File: doc/BRIEF.md
# Interrupt Level Arbiter for a Group of Timer Channels

This block gathers interrupt events from a group of timer channels (eleven by default) and presents them to a system bus. Each channel has a programmed request level from 1 to 7 and a single arbitration bit. The block keeps one pending flag per channel. It raises one of seven level lines for every level at which an enabled channel is pending. A level of 0 keeps a channel silent.

When the bus arbitrates at a level, it presents that level and a 4-bit arbitration number. The upper three bits of that number must equal a block-wide setting. The low bit selects which channels may take part: only those whose own arbitration bit matches it. The block therefore answers to two arbitration numbers at most. On acknowledge, the block latches the lowest-numbered eligible channel. It returns an 8-bit vector built from two programmable high bits and the 6-bit channel index. Only the channel's own clear input removes its pending flag.

Top module: `irq_level_arb`

## Requirements
- R1: A `set_req` bit sets that channel's pending flag at the next clock edge. When `set_req` and `clr_req` are both high for the same channel, the flag ends up set.
- R2: A pending flag is cleared only by the channel's own `clr_req`. An acknowledge that selects a channel leaves its flag set.
- R3: `irq_lines` bit k-1 is high one cycle after the pending flags show an enabled channel programmed to level k. A channel at level 0 drives no line.
- R4: `arb_hit` goes high in the cycle after `arb_strobe` exactly when two conditions hold: `arb_num[3:1]` equals `mod_arb_hi`, and at least one channel is eligible. A channel is eligible when it is pending, its level is nonzero and equal to `arb_level`, and its arbitration bit equals `arb_num[0]`.
- R5: On `ack` with a match and at least one eligible channel, `vec_valid` pulses for one cycle on the next cycle. At the same time `vec_out` becomes {`vec_hi`, 6-bit index of the lowest-numbered eligible channel}.
- R6: On `ack` with no eligible channel, or with `arb_num[3:1]` different from `mod_arb_hi`, `vec_valid` stays low and `vec_out` keeps its value.
- R7: `vec_out` changes only on a cycle in which `vec_valid` is high.
- R8: While `rst` is high, at the clock edge all pending flags, `irq_lines`, `arb_hit`, `vec_valid` and `vec_out` go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | 11 | Per-channel request event |
| clr_req | input | 11 | Per-channel pending clear |
| src_level | input | 33 | Packed 3-bit level per channel, channel i at bits [3i+2:3i] |
| src_arb | input | 11 | Per-channel arbitration bit |
| mod_arb_hi | input | 3 | Block-wide upper three bits of the arbitration number |
| vec_hi | input | 2 | Upper two bits of the returned vector |
| arb_strobe | input | 1 | Bus arbitration cycle at `arb_level` / `arb_num` |
| ack | input | 1 | Bus acknowledge at `arb_level` / `arb_num` |
| arb_level | input | 3 | Level being arbitrated |
| arb_num | input | 4 | Arbitration number being presented |
| irq_lines | output | 7 | Level request lines, bit k-1 for level k |
| arb_hit | output | 1 | Block claims the arbitration cycle |
| vec_valid | output | 1 | One-cycle pulse: new vector on `vec_out` |
| vec_out | output | 8 | Vector of the acknowledged channel |

## Verification
Two events can land in the same clock edge: an acknowledge, and a request event or clear on one of the channels it is choosing among. The bench provokes this directly. It raises a lower-numbered channel's `set_req` in the ack cycle, and it clears the chosen channel in the ack cycle. In both cases the vector must reflect the pending flags from before that edge, and the next acknowledge must reflect the updated flags. A behavioural reference model, stepped on every clock edge, compares all four outputs during a long run of mixed random stimulus.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W    = 3;
  localparam int IDX_W    = 6;
  localparam int ARB_HI_W = 3;
  localparam int VHI_W    = 2;
  localparam int N_LINES  = (1 << LVL_W) - 1;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_req,
  input  logic [N_SRC-1:0] clr_req,
  output logic [N_SRC-1:0] pend
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             pend[i] <= 1'b0;
      else if (set_req[i]) pend[i] <= 1'b1;
      else if (clr_req[i]) pend[i] <= 1'b0;
    end

    // R1: a request event always leaves the flag set
    assert_set_wins_R1: assert property (@(posedge clk) disable iff (rst)
      set_req[i] |=> pend[i]);
    // R2: a lone clear removes the flag
    assert_clear_only_R2: assert property (@(posedge clk) disable iff (rst)
      (clr_req[i] && !set_req[i]) |=> !pend[i]);
    // R2: without a clear, the flag cannot fall
    assert_no_drop_R2: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !clr_req[i]) |=> pend[i]);
  end
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 11
) (
  input  logic [N_SRC-1:0]       pend,
  input  logic [N_SRC*LVL_W-1:0] src_level,
  input  logic [N_SRC-1:0]       src_arb,
  input  logic [LVL_W-1:0]       arb_level,
  input  logic                   arb_bit,
  output logic [N_LINES-1:0]     lines,
  output logic [N_SRC-1:0]       elig
);
  logic [LVL_W-1:0] lv [N_SRC];

  for (genvar i = 0; i < N_SRC; i++) begin : g_lv
    assign lv[i] = src_level[i*LVL_W +: LVL_W];
  end

  always_comb begin
    lines = '0;
    for (int k = 1; k <= N_LINES; k++) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (pend[i] && lv[i] == LVL_W'(k)) lines[k-1] = 1'b1;
      end
    end
  end

  always_comb begin
    elig = '0;
    for (int i = 0; i < N_SRC; i++) begin
      elig[i] = pend[i] && (lv[i] != '0) && (lv[i] == arb_level) &&
                (src_arb[i] == arb_bit);
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 11
) (
  input  logic [N_SRC-1:0] elig,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R5: chosen index is eligible and no lower index is
  always_comb begin
    if (found) begin
      assert_pick_lowest_R5: assert (elig[idx] &&
        ((elig & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0));
    end
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       set_req,
  input  logic [N_SRC-1:0]       clr_req,
  input  logic [N_SRC*LVL_W-1:0] src_level,
  input  logic [N_SRC-1:0]       src_arb,
  input  logic [ARB_HI_W-1:0]    mod_arb_hi,
  input  logic [VHI_W-1:0]       vec_hi,
  input  logic                   arb_strobe,
  input  logic                   ack,
  input  logic [LVL_W-1:0]       arb_level,
  input  logic [ARB_HI_W:0]      arb_num,
  output logic [N_LINES-1:0]     irq_lines,
  output logic                   arb_hit,
  output logic                   vec_valid,
  output logic [VHI_W+IDX_W-1:0] vec_out
);
  logic [N_SRC-1:0]   pend;
  logic [N_LINES-1:0] lines_c;
  logic [N_SRC-1:0]   elig;
  logic               found;
  logic [IDX_W-1:0]   idx;
  logic               num_match;

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst(rst), .set_req(set_req), .clr_req(clr_req), .pend(pend)
  );

  irq_level_map #(.N_SRC(N_SRC)) u_map (
    .pend(pend), .src_level(src_level), .src_arb(src_arb),
    .arb_level(arb_level), .arb_bit(arb_num[0]),
    .lines(lines_c), .elig(elig)
  );

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .elig(elig), .found(found), .idx(idx)
  );

  assign num_match = (arb_num[ARB_HI_W:1] == mod_arb_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lines <= '0;
      arb_hit   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      irq_lines <= lines_c;
      arb_hit   <= arb_strobe && num_match && found;
      vec_valid <= ack && num_match && found;
      if (ack && num_match && found) vec_out <= {vec_hi, idx};
    end
  end

  // R4: a claim only follows an arbitration strobe
  assert_hit_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    arb_hit |-> $past(arb_strobe));
  // R5: a vector only follows an acknowledge, and names a real channel
  assert_valid_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ($past(ack) && (vec_out[IDX_W-1:0] < IDX_W'(N_SRC))));
  // R7: vector holds unless a new one is delivered
  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |-> $stable(vec_out));
  // R6: an acknowledge with foreign upper bits never yields a vector
  assert_foreign_num_R6: assert property (@(posedge clk) disable iff (rst)
    (ack && !num_match) |=> !vec_valid);
endmodule

// File: tb/irq_level_arb_test.sv
module irq_level_arb_test;
  localparam int N = 11;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] set_req, clr_req, src_arb;
  logic [N*3-1:0] src_level;
  logic [2:0]   mod_arb_hi, arb_level;
  logic [1:0]   vec_hi;
  logic         arb_strobe, ack;
  logic [3:0]   arb_num;
  logic [6:0]   irq_lines;
  logic         arb_hit, vec_valid;
  logic [7:0]   vec_out;

  int nchk = 0, nerr = 0;
  bit done = 0, started = 0;

  // reference model state
  bit [N-1:0] m_pend;
  bit [6:0]   m_lines;
  bit         m_hit, m_valid;
  bit [7:0]   m_vec;

  always #5 clk = ~clk;

  irq_level_arb #(.N_SRC(N)) uut (
    .clk(clk), .rst(rst), .set_req(set_req), .clr_req(clr_req),
    .src_level(src_level), .src_arb(src_arb), .mod_arb_hi(mod_arb_hi),
    .vec_hi(vec_hi), .arb_strobe(arb_strobe), .ack(ack),
    .arb_level(arb_level), .arb_num(arb_num), .irq_lines(irq_lines),
    .arb_hit(arb_hit), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: one step per clock edge
  always @(posedge clk) begin
    if (rst) begin
      m_pend = '0; m_lines = '0; m_hit = 0; m_valid = 0; m_vec = '0;
    end else begin
      bit [6:0] nl;
      int pick;
      bit hi_ok;
      nl = '0; pick = -1;
      for (int i = 0; i < N; i++) begin
        int lv;
        lv = int'(src_level[i*3 +: 3]);
        if (m_pend[i] && lv != 0) begin
          nl[lv-1] = 1'b1;
          if (lv == int'(arb_level) && src_arb[i] == arb_num[0] && pick < 0) pick = i;
        end
      end
      hi_ok   = (arb_num[3:1] == mod_arb_hi);
      m_lines = nl;
      m_hit   = arb_strobe && hi_ok && pick >= 0;
      m_valid = ack && hi_ok && pick >= 0;
      if (m_valid) m_vec = {vec_hi, 6'(pick)};
      for (int i = 0; i < N; i++) begin
        if (set_req[i]) m_pend[i] = 1'b1;
        else if (clr_req[i]) m_pend[i] = 1'b0;
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3 lines", int'(irq_lines), int'(m_lines));
      chk("R4 hit", int'(arb_hit), int'(m_hit));
      chk("R5 valid", int'(vec_valid), int'(m_valid));
      chk("R7 vector", int'(vec_out), int'(m_vec));
    end
  end

  task automatic set_cfg(int i, int lv, bit ab);
    src_level[i*3 +: 3] = 3'(lv);
    src_arb[i] = ab;
  endtask

  task automatic do_ack(int lv, bit [3:0] num);
    @(negedge clk); ack = 1; arb_level = 3'(lv); arb_num = num;
    @(negedge clk); ack = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst = 1; set_req = '0; clr_req = '0; src_level = '0; src_arb = '0;
    mod_arb_hi = 3'b101; vec_hi = 2'b10; arb_strobe = 0; ack = 0;
    arb_level = '0; arb_num = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset lines", int'(irq_lines), 0);
    chk("R8 reset vec", int'(vec_out), 0);
    chk("R8 reset valid", int'(vec_valid), 0);
    chk("R8 reset hit", int'(arb_hit), 0);
    rst = 0;

    set_cfg(3, 2, 0); set_cfg(7, 2, 1); set_cfg(9, 0, 0);
    set_cfg(1, 2, 0); set_cfg(5, 4, 0);
    @(negedge clk); set_req = 11'(1<<3 | 1<<7 | 1<<9);
    @(negedge clk); set_req = '0;
    @(negedge clk);
    chk("R3 level2 only, level0 silent", int'(irq_lines), 'h02);

    @(negedge clk); arb_strobe = 1; arb_level = 2; arb_num = 4'b1010;
    @(negedge clk); arb_strobe = 0;
    chk("R4 claim on match", int'(arb_hit), 1);
    @(negedge clk); arb_strobe = 1; arb_level = 2; arb_num = 4'b1000;
    @(negedge clk); arb_strobe = 0;
    chk("R4 no claim on foreign upper bits", int'(arb_hit), 0);

    do_ack(2, 4'b1010);
    chk("R5 valid", int'(vec_valid), 1);
    chk("R5 lowest with bit 0", int'(vec_out), 'h83);
    do_ack(2, 4'b1011);
    chk("R5 arb bit selects channel 7", int'(vec_out), 'h87);
    do_ack(3, 4'b1010);
    chk("R6 no eligible valid", int'(vec_valid), 0);
    chk("R6 vector kept", int'(vec_out), 'h87);
    do_ack(2, 4'b0010);
    chk("R6 foreign upper bits", int'(vec_valid), 0);
    repeat (3) @(negedge clk);
    chk("R7 vector held", int'(vec_out), 'h87);
    do_ack(2, 4'b1010);
    chk("R2 ack leaves flag", int'(vec_out), 'h83);

    // ack and set of a lower channel in the same cycle
    @(negedge clk); ack = 1; arb_level = 2; arb_num = 4'b1010; set_req[1] = 1;
    @(negedge clk); ack = 0; set_req = '0;
    chk("R5 same-cycle set not seen", int'(vec_out), 'h83);
    do_ack(2, 4'b1010);
    chk("R5 new lower channel wins", int'(vec_out), 'h81);
    // ack and clear of the chosen channel in the same cycle
    @(negedge clk); ack = 1; arb_level = 2; arb_num = 4'b1010; clr_req[1] = 1;
    @(negedge clk); ack = 0; clr_req = '0;
    chk("R2 same-cycle clear still served", int'(vec_out), 'h81);
    do_ack(2, 4'b1010);
    chk("R2 cleared channel gone", int'(vec_out), 'h83);

    @(negedge clk); set_req[5] = 1; clr_req[5] = 1;
    @(negedge clk); set_req = '0; clr_req = '0;
    @(negedge clk);
    chk("R1 set beats clear", int'(irq_lines[3]), 1);
    @(negedge clk); clr_req[5] = 1;
    @(negedge clk); clr_req = '0;
    @(negedge clk);
    chk("R2 clear drops line", int'(irq_lines[3]), 0);

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (c % 200 == 0) begin
        for (int i = 0; i < N; i++) set_cfg(i, $urandom_range(0, 7), 1'($urandom));
        mod_arb_hi = 3'($urandom); vec_hi = 2'($urandom);
      end
      set_req = '0; clr_req = '0;
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(0, 15) == 0) set_req[i] = 1;
        if ($urandom_range(0, 11) == 0) clr_req[i] = 1;
      end
      arb_strobe = ($urandom_range(0, 2) == 0);
      ack = ($urandom_range(0, 2) == 0);
      arb_level = 3'($urandom);
      arb_num = {($urandom_range(0, 3) == 0) ? 3'($urandom) : mod_arb_hi, 1'($urandom)};
    end
    @(negedge clk); set_req = '0; clr_req = '0; arb_strobe = 0; ack = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule